// File: doc/BRIEF.md
# Serial Receive Buffer with Software Flow Control

This block is the receive half of an asynchronous serial link of the kind a printer uses. It oversamples the line at sixteen times the bit rate and frames each character. Data length, parity enable and parity sense are set at run time. Finished bytes are written into an internal FIFO, and a downstream consumer reads them through a valid/ready byte port. A character whose parity check fails is stored as an asterisk. A character with a bad stop bit is kept as if nothing were wrong. A character that arrives while the buffer is full is dropped without any indication.

The block tracks the free space in its buffer and drives a busy flag with hysteresis. When free space drops to the low mark or below, busy rises and a request to send the stop code (0x13) is raised. When free space climbs above the high mark, busy falls and a request to send the resume code (0x11) is raised. The transmit path sees a request that stays up until it acknowledges it. If the resume code falls due before the stop code has been taken, the pending code is swapped for the resume code.

Top module: `rx_flow_buffer`

## Requirements
- R1: After reset the buffer is empty (out_valid low), busy is low and fc_req is low.
- R2: With 8-bit data and parity disabled, a frame is one low start bit, eight data bits sent least significant bit first, and one stop bit. Each byte is stored and presented on out_data in arrival order. A byte is removed in the cycle where out_valid and out_ready are both high.
- R3: With cfg_seven_bits high, a frame carries seven data bits, and the stored byte has bit 7 equal to 0.
- R4: With cfg_parity_en high, one parity bit follows the data bits. cfg_parity_odd low selects even parity (the data ones plus the parity bit give an even count) and high selects odd parity. A character that passes the check is stored unchanged.
- R5: A character that fails the enabled parity check is stored as 0x2A in place of its data.
- R6: A character whose stop bit is sampled low is stored like a good character, and no error is reported.
- R7: A character that completes while the buffer holds DEPTH bytes is discarded. The buffer contents and their order are unchanged, and no error is reported.
- R8: When free space (DEPTH minus occupancy) becomes less than or equal to XOFF_FREE while busy is low, busy goes high and fc_req rises once with fc_code = 0x13.
- R9: When free space becomes greater than XON_FREE while busy is high, busy goes low and fc_req is raised with fc_code = 0x11.
- R10: fc_req stays high until a cycle with fc_ack high, and then it falls.
- R11: If the resume condition of R9 arises while the stop request is still unacknowledged, fc_code changes to 0x11 and fc_req stays high.
- R12: A low pulse on rxd shorter than half a bit time is not taken as a start bit, and no byte is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_seven_bits | input | 1 | 1: seven data bits, 0: eight |
| cfg_parity_en | input | 1 | 1: a parity bit is present and checked |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even parity |
| out_data | output | 8 | Oldest buffered byte |
| out_valid | output | 1 | Buffer is not empty |
| out_ready | input | 1 | Consumer takes out_data this cycle |
| busy | output | 1 | Flow-control busy flag |
| fc_req | output | 1 | Flow-control character request, held until acknowledged |
| fc_code | output | 8 | Requested character: 0x13 stop, 0x11 resume |
| fc_ack | input | 1 | Transmit side has taken the request |

## Verification
The framer is driven with eight-bit plain frames, seven-bit frames whose top data bit would otherwise be set, and even and odd parity frames, each with good and corrupted parity bits. These show whether the data length, the parity sense and the asterisk substitution are each applied. Frames with a low stop bit and a short low glitch separate tolerant framing from false start detection. The buffer is filled one byte below the stop mark, onto the mark and then past full, and is then drained. This shows where the hysteresis marks sit, that each request is raised once, that overrun bytes are dropped, and that an unacknowledged stop request is replaced by a resume request.

// File: rtl/rx_flow_pkg.sv
package rx_flow_pkg;
   localparam logic [7:0] CODE_RESUME = 8'h11;
   localparam logic [7:0] CODE_STOP   = 8'h13;
   localparam logic [7:0] CODE_BADPAR = 8'h2A;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
   } rx_state_t;
endpackage

// File: rtl/rx_flow_tick.sv
module rx_flow_tick #(
   parameter int CLKS_PER_TICK = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (CLKS_PER_TICK < 1) begin : g_bad
      $error("CLKS_PER_TICK must be at least 1");
   end

   if (CLKS_PER_TICK == 1) begin : g_every
      assign tick = 1'b1;
   end else begin : g_div
      localparam int DW = $clog2(CLKS_PER_TICK);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
         if (!rst_n || div_q == DW'(CLKS_PER_TICK - 1)) div_q <= '0;
         else                                             div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == '0);
   end
endmodule

// File: rtl/rx_flow_framer.sv
module rx_flow_framer
   import rx_flow_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   input  logic       seven_bits,
   input  logic       par_en,
   input  logic       par_odd,
   output logic       char_valid,
   output logic [7:0] char_byte
);
   logic [2:0] sync_q;
   rx_state_t  st_q;
   logic [3:0] phase_q;
   logic [2:0] bit_idx_q;
   logic [7:0] shreg_q;
   logic       pbit_q;
   logic       line, fall, par_bad;
   logic [2:0] last_idx;

   assign line     = sync_q[1];
   assign fall     = sync_q[2] & ~sync_q[1];
   assign last_idx = seven_bits ? 3'd6 : 3'd7;
   assign par_bad  = par_en & (^shreg_q ^ pbit_q ^ par_odd);

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= 3'b111;
      else        sync_q <= {sync_q[1:0], rxd};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= RX_IDLE;
         phase_q    <= '0;
         bit_idx_q  <= '0;
         shreg_q    <= '0;
         pbit_q     <= 1'b0;
         char_valid <= 1'b0;
         char_byte  <= '0;
      end else begin
         char_valid <= 1'b0;
         if (st_q == RX_IDLE) begin
            if (fall) begin
               st_q    <= RX_START;
               phase_q <= '0;
               shreg_q <= '0;
            end
         end else if (tick) begin
            phase_q <= phase_q + 1'b1;
            unique case (st_q)
               RX_START: if (phase_q == 4'd7) begin
                  phase_q   <= '0;
                  bit_idx_q <= '0;
                  st_q      <= line ? RX_IDLE : RX_DATA;
               end
               RX_DATA: if (phase_q == 4'd15) begin
                  shreg_q[bit_idx_q] <= line;
                  bit_idx_q          <= bit_idx_q + 1'b1;
                  if (bit_idx_q == last_idx) st_q <= par_en ? RX_PARITY : RX_STOP;
               end
               RX_PARITY: if (phase_q == 4'd15) begin
                  pbit_q <= line;
                  st_q   <= RX_STOP;
               end
               RX_STOP: if (phase_q == 4'd15) begin
                  char_valid <= 1'b1;
                  char_byte  <= par_bad ? CODE_BADPAR : shreg_q;
                  st_q       <= RX_IDLE;
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   p_seven_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && seven_bits) |-> !char_byte[7]);
   p_start_mid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RX_DATA && $past(st_q) == RX_START) |-> !$past(line));
endmodule

// File: rtl/rx_flow_fifo.sv
module rx_flow_fifo #(
   parameter int DEPTH = 1024,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [7:0]    push_data,
   input  logic          pop,
   output logic [7:0]    head,
   output logic          not_empty,
   output logic [CW-1:0] fill
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad
      $error("DEPTH must be a power of two of at least 2");
   end

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic          full, do_push, do_pop;

   assign full      = (fill == CW'(DEPTH));
   assign not_empty = (fill != '0);
   assign do_push   = push & ~full;
   assign do_pop    = pop & not_empty;
   assign head      = mem[rd_q];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
         fill <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + 1'b1;
         if (do_pop)  rd_q <= rd_q + 1'b1;
         fill <= fill + CW'(do_push) - CW'(do_pop);
      end
   end

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (fill == CW'(DEPTH) && $stable(wr_q)));
   p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!not_empty && pop && !push) |=> (fill == '0 && $stable(rd_q)));
endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl
   import rx_flow_pkg::*;
#(
   parameter int DEPTH     = 1024,
   parameter int XOFF_FREE = 256,
   parameter int XON_FREE  = 528,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] fill,
   input  logic          ack,
   output logic          busy,
   output logic          req,
   output logic [7:0]    code
);
   if (!(XOFF_FREE < XON_FREE && XON_FREE < DEPTH)) begin : g_bad
      $error("marks must satisfy XOFF_FREE < XON_FREE < DEPTH");
   end

   logic [CW-1:0] space;
   logic          go_stop, go_resume;

   assign space     = CW'(DEPTH) - fill;
   assign go_stop   = ~busy & (space <= CW'(XOFF_FREE));
   assign go_resume =  busy & (space >  CW'(XON_FREE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         req  <= 1'b0;
         code <= CODE_RESUME;
      end else if (go_stop) begin
         busy <= 1'b1;
         req  <= 1'b1;
         code <= CODE_STOP;
      end else if (go_resume) begin
         busy <= 1'b0;
         req  <= 1'b1;
         code <= CODE_RESUME;
      end else if (ack) begin
         req  <= 1'b0;
      end
   end

   p_stop_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && space <= CW'(XOFF_FREE)) |=> (busy && req && code == CODE_STOP));
   p_resume_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && space > CW'(XON_FREE)) |=> (!busy && req && code == CODE_RESUME));
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> req);
   p_req_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $changed(busy));
endmodule

// File: rtl/rx_flow_buffer.sv
module rx_flow_buffer #(
   parameter int CLKS_PER_TICK = 4,
   parameter int DEPTH         = 1024,
   parameter int XOFF_FREE     = 256,
   parameter int XON_FREE      = 528
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   input  logic       cfg_seven_bits,
   input  logic       cfg_parity_en,
   input  logic       cfg_parity_odd,
   output logic [7:0] out_data,
   output logic       out_valid,
   input  logic       out_ready,
   output logic       busy,
   output logic       fc_req,
   output logic [7:0] fc_code,
   input  logic       fc_ack
);
   localparam int CW = $clog2(DEPTH + 1);

   logic          tick, char_valid;
   logic [7:0]    char_byte;
   logic [CW-1:0] fill;

   rx_flow_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   rx_flow_framer u_framer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
      .seven_bits(cfg_seven_bits), .par_en(cfg_parity_en),
      .par_odd(cfg_parity_odd), .char_valid(char_valid),
      .char_byte(char_byte));

   rx_flow_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(char_valid), .push_data(char_byte),
      .pop(out_ready), .head(out_data), .not_empty(out_valid), .fill(fill));

   rx_flow_ctrl #(.DEPTH(DEPTH), .XOFF_FREE(XOFF_FREE), .XON_FREE(XON_FREE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .fill(fill), .ack(fc_ack),
      .busy(busy), .req(fc_req), .code(fc_code));

   p_reset_idle_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!out_valid && !busy && !fc_req));
endmodule

// File: tb/rx_flow_buffer_test.sv
`timescale 1ns/1ps
module rx_flow_buffer_test;
   localparam int DIV    = 2;
   localparam int BITCLK = 16 * DIV;
   localparam int DEPTH  = 64;
   localparam int LOWM   = 16;
   localparam int HIGHM  = 33;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       cfg_seven_bits = 1'b0, cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0;
   logic [7:0] out_data;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic       busy, fc_req;
   logic [7:0] fc_code;
   logic       fc_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   int pops = 0;
   int req_rises = 0;
   logic req_prev = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   rx_flow_buffer #(.CLKS_PER_TICK(DIV), .DEPTH(DEPTH), .XOFF_FREE(LOWM),
                    .XON_FREE(HIGHM)) uut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_seven_bits(cfg_seven_bits),
      .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
      .busy(busy), .fc_req(fc_req), .fc_code(fc_code), .fc_ack(fc_ack));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (fc_req && !req_prev) req_rises++;
         req_prev = fc_req;
         if (out_valid && out_ready) begin
            pops++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected byte", out_data, 0);
            end else begin
               check(out_data == exp_q[0], tag_q[0], out_data, exp_q[0]);
               void'(exp_q.pop_front());
               void'(tag_q.pop_front());
            end
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<190000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic line_bit(input logic b);
      rxd = b;
      repeat (BITCLK) @(posedge clk);
      #1;
   endtask

   task automatic send(input logic [7:0] d, input bit seven, input bit pen,
                       input bit podd, input bit bad_par, input bit bad_stop,
                       input bit store, input string tag);
      logic [7:0] v;
      logic       p;
      int         n;
      n = seven ? 7 : 8;
      v = seven ? {1'b0, d[6:0]} : d;
      p = (^v) ^ podd ^ bad_par;
      cfg_seven_bits = seven;
      cfg_parity_en  = pen;
      cfg_parity_odd = podd;
      if (store) begin
         exp_q.push_back((pen && bad_par) ? 8'h2A : v);
         tag_q.push_back(tag);
      end
      line_bit(1'b0);
      for (int i = 0; i < n; i++) line_bit(v[i]);
      if (pen) line_bit(p);
      line_bit(~bad_stop);
      line_bit(1'b1);
   endtask

   task automatic drain;
      out_ready = 1'b1;
      while (exp_q.size() != 0) @(posedge clk);
      repeat (8) @(posedge clk);
      #1;
      out_ready = 1'b0;
   endtask

   task automatic ack_req;
      @(posedge clk); #1 fc_ack = 1'b1;
      @(posedge clk); #1 fc_ack = 1'b0;
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid, "R1 out_valid", out_valid, 0);
      check(!busy, "R1 busy", busy, 0);
      check(!fc_req, "R1 fc_req", fc_req, 0);
      @(posedge clk); #1;

      out_ready = 1'b1;
      send(8'hA5, 0, 0, 0, 0, 0, 1, "R2 8bit");
      send(8'h3C, 0, 0, 0, 0, 0, 1, "R2 8bit");
      send(8'hC1, 1, 0, 0, 0, 0, 1, "R3 7bit");
      send(8'hFF, 1, 0, 0, 0, 0, 1, "R3 7bit");
      send(8'h96, 0, 1, 0, 0, 0, 1, "R4 even");
      send(8'h97, 0, 1, 1, 0, 0, 1, "R4 odd");
      send(8'h45, 1, 1, 0, 0, 0, 1, "R4 7bit even");
      send(8'h81, 0, 1, 0, 1, 0, 1, "R5 even bad");
      send(8'h7E, 0, 1, 1, 1, 0, 1, "R5 odd bad");
      send(8'h5A, 0, 0, 0, 0, 1, 1, "R6 low stop");
      send(8'h12, 0, 0, 0, 0, 0, 1, "R6 after low stop");
      drain();

      // R12: short glitch
      begin
         int p0;
         p0 = pops;
         rxd = 1'b0;
         repeat (BITCLK / 4) @(posedge clk);
         #1 rxd = 1'b1;
         repeat (BITCLK * 24) @(posedge clk);
         @(negedge clk);
         check(pops == p0 && !out_valid, "R12 glitch", pops - p0, 0);
         @(posedge clk); #1;
      end
      send(8'h6B, 0, 0, 0, 0, 0, 1, "R12 after glitch");
      drain();

      // R8: fill to one above the stop mark, then onto it
      pops = 0;
      for (int i = 0; i < DEPTH - LOWM - 1; i++) send(8'(i), 0, 0, 0, 0, 0, 1, "R7 fill");
      check(!busy && !fc_req, "R8 below mark", {busy, fc_req}, 0);
      send(8'hB0, 0, 0, 0, 0, 0, 1, "R7 fill");
      check(busy && fc_req && fc_code == 8'h13, "R8 stop req",
            {busy, fc_req, fc_code}, {2'b11, 8'h13});
      repeat (100) @(posedge clk);
      #1;
      check(fc_req, "R10 held", fc_req, 1);
      check(req_rises == 1, "R8 once", req_rises, 1);
      ack_req();
      check(!fc_req, "R10 ack", fc_req, 0);

      // R7: fill to full, then one more
      for (int i = 0; i < LOWM; i++) send(8'(8'hC0 + i), 0, 0, 0, 0, 0, 1, "R7 fill");
      send(8'hEE, 0, 0, 0, 0, 0, 0, "R7 overrun");
      check(req_rises == 1 && !fc_req, "R8 no repeat", req_rises, 1);
      drain();
      check(pops == DEPTH && !out_valid, "R7 count", pops, DEPTH);
      check(!busy && fc_req && fc_code == 8'h11, "R9 resume req",
            {busy, fc_req, fc_code}, {2'b01, 8'h11});
      ack_req();
      check(!fc_req, "R10 ack resume", fc_req, 0);

      // R11: resume due before stop acknowledged
      for (int i = 0; i < DEPTH - LOWM; i++) send(8'(8'h40 ^ i), 0, 0, 0, 0, 0, 1, "R11 fill");
      check(fc_req && fc_code == 8'h13, "R11 stop pending", fc_code, 8'h13);
      drain();
      check(fc_req && fc_code == 8'h11 && !busy, "R11 replaced", {fc_req, fc_code}, {1'b1, 8'h11});
      check(req_rises == 3, "R11 single rise", req_rises, 3);
      ack_req();
      check(!fc_req, "R10 final ack", fc_req, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule